// File: doc/BRIEF.md
# Two-wire start detector with clock hold

This block is the slave-side front end of a serial interface running in two-wire mode. It samples the open-drain data (SDA) and clock (SCL) lines through a synchroniser and recognises a start condition: SDA falling while SCL stays high. A start sets a start flag. The flag can raise an interrupt request. The block then waits for the master's next SCL falling edge and pulls SCL low itself. The clock stays stretched until software has cleared the flag and zeroed the edge counter, which gives slow firmware time to prepare before the address byte is clocked.

Outside a start, every SCL rising edge shifts the sampled SDA level into the LSB of a data register, so bits arrive MSB first. The register's MSB, when the output enable is set, pulls SDA low. A counter counts both edges of SCL, so a byte takes 16 edges. The counter wraps after the last edge of a byte and sets an overflow flag. In the first frame after a start, the 7 address bits and the read/write bit take the eight shift clocks and clock 9 is the acknowledge. Data frames carry 8 bits and then an acknowledge. Software sees the block through a small register port with a single-cycle write strobe and a combinational read.

Both line outputs are active-low pull enables. The line is low whenever this block or any other driver pulls it. The register port is plain control with no valid/ready handshake, because every access completes in one cycle and nothing is queued.

Top module: `tw_start_hold`

## Requirements
- R1: After reset the start flag, the overflow flag, the counter and the control bits read 0, the data register reads 0xFF, both pull outputs are 1 (released) and `irq` is 0.
- R2: SDA falling while SCL is high sets the start flag, which is status bit 7 (`reg_sel`=1). SDA falling while SCL is low leaves the flag at 0. Writing 1 to status bit 7 clears the flag.
- R3: `irq` is 1 exactly when the start flag is set and the interrupt enable, control bit 0 (`reg_sel`=2), is 1.
- R4: While the start flag is set, the first SCL falling edge makes `scl_pull_n` go 0, and it stays 0 while the flag remains set.
- R5: A held SCL is released (`scl_pull_n` back to 1) only once the start flag is 0 and the counter is 0. Clearing the flag while the counter is non-zero keeps the hold.
- R6: `sda_pull_n` is 0 exactly when output enable (control bit 1) is 1 and bit 7 of the data register (`reg_sel`=0) is 0.
- R7: With the start flag clear, each SCL rising edge shifts the sampled SDA into bit 0 and moves the existing bits up, so after eight rising edges the data register holds the received byte MSB first. A write to the data register loads it directly.
- R8: With the start flag clear, the counter (status bits 3:0) advances on every SCL edge. On the 16th edge it wraps from 15 to 0 and sets the overflow flag (status bit 6). Writing 1 to bit 6 clears it. Any status write loads bits 3:0 into the counter.
- R9: A start detected in the same cycle as a software clear of the start flag leaves the flag set.
- R10: While the start flag is set the counter and data register do not change on SCL edges, so the master's falling edge that triggers the hold is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Level seen on the SDA line |
| scl_in | input | 1 | Level seen on the SCL line |
| sda_pull_n | output | 1 | 0 pulls SDA low |
| scl_pull_n | output | 1 | 0 holds SCL low |
| irq | output | 1 | Start interrupt request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |

## Verification
The start detector and a software clear of the start flag can act in the same clock. The bench provokes this by timing a status write of bit 7 to the cycle in which the synchronised SDA fall first appears with SCL high, which is three clock edges after the line changes. It then reads the flag and expects it still set. The bench checks the hold the same way: it clears the flag while the counter is non-zero and expects SCL to stay held until a later write zeroes the counter.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_IE_BIT = 0;
  localparam int CTRL_OE_BIT = 1;

  // Counter width for a byte counted on both SCL edges
  function automatic int edge_cnt_width(input int data_w);
    return $clog2(2 * data_w);
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/tw_line_events.sv
module tw_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic sda_q, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
    end
  end

  // SDA high-to-low with SCL high on both samples
  assign start_det = sda_q & ~sda_s & scl_q & scl_s;
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
endmodule

// File: rtl/tw_shift_count.sv
module tw_shift_count #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              count_en,
  input  logic              sda_s,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wval,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wval,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_q
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * DATA_W - 1);

  logic wrap;
  assign wrap = count_en && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '1;
    else if (data_wr)  data_q <= data_wval;
    else if (shift_en) data_q <= {data_q[DATA_W-2:0], sda_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_wr)   cnt_q <= cnt_wval;
    else if (count_en) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (wrap)    ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end
endmodule

// File: rtl/tw_start_hold.sv
module tw_start_hold
  import tw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_pull_n,
  output logic              scl_pull_n,
  output logic              irq,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_W = edge_cnt_width(DATA_W);

  reg_sel_e          sel;
  logic              sda_s, scl_s;
  logic              start_det, scl_rise, scl_fall;
  logic              flag_q, hold_q, ie_q, oe_q;
  logic              data_wr, stat_wr, ctrl_wr, flag_clr;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;

  assign sel     = reg_sel_e'(reg_sel);
  assign data_wr = reg_wr && (sel == SEL_DATA);
  assign stat_wr = reg_wr && (sel == SEL_STAT);
  assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
  assign flag_clr = stat_wr && reg_wdata[DATA_W-1];

  tw_sync #(.STAGES(SYNC_STAGES), .LANES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sda_in, scl_in}),
    .q     ({sda_s, scl_s})
  );

  tw_line_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_s     (scl_s),
    .start_det (start_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  tw_shift_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (scl_rise & ~flag_q),
    .count_en  ((scl_rise | scl_fall) & ~flag_q),
    .sda_s     (sda_s),
    .data_wr   (data_wr),
    .data_wval (reg_wdata),
    .cnt_wr    (stat_wr),
    .cnt_wval  (reg_wdata[CNT_W-1:0]),
    .ovf_clr   (stat_wr && reg_wdata[DATA_W-2]),
    .data_q    (data_q),
    .cnt_q     (cnt_q),
    .ovf_q     (ovf_q)
  );

  // start flag: detection wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (start_det) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  // clock hold: armed by first SCL fall during a start, freed when flag and counter are clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               hold_q <= 1'b0;
    else if (scl_fall && flag_q)              hold_q <= 1'b1;
    else if (!flag_q && cnt_q == CNT_W'(0))   hold_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (ctrl_wr) begin
      ie_q <= reg_wdata[CTRL_IE_BIT];
      oe_q <= reg_wdata[CTRL_OE_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_DATA: reg_rdata = data_q;
      SEL_STAT: begin
        reg_rdata[DATA_W-1]  = flag_q;
        reg_rdata[DATA_W-2]  = ovf_q;
        reg_rdata[CNT_W-1:0] = cnt_q;
      end
      SEL_CTRL: begin
        reg_rdata[CTRL_IE_BIT] = ie_q;
        reg_rdata[CTRL_OE_BIT] = oe_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign scl_pull_n = ~hold_q;
  assign sda_pull_n = ~(oe_q & ~data_q[DATA_W-1]);
  assign irq        = flag_q & ie_q;
endmodule

// File: rtl/tw_start_hold_chk.sv
module tw_start_hold_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_det,
  input logic             start_flag,
  input logic             scl_pull_n,
  input logic             sda_pull_n,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_load,
  input logic             ovf
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * DATA_W - 1);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (scl_pull_n && sda_pull_n && !irq)); // R1

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> start_flag); // R3

  AST_HOLD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull_n) |-> $past(start_flag)); // R4

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_n) |-> ($past(!start_flag) && $past(cnt) == CNT_W'(0))); // R5

  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> start_flag); // R9

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_flag) && !$past(cnt_load)) |-> $stable(cnt)); // R10

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == LAST && cnt == CNT_W'(0) && !$past(cnt_load)) |-> ovf); // R8
endmodule

bind tw_start_hold tw_start_hold_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_det  (start_det),
  .start_flag (flag_q),
  .scl_pull_n (scl_pull_n),
  .sda_pull_n (sda_pull_n),
  .irq        (irq),
  .cnt        (cnt_q),
  .cnt_load   (stat_wr),
  .ovf        (ovf_q)
);

// File: tb/tw_start_hold_bench.sv
module tw_start_hold_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sda_m = 1'b1, scl_m = 1'b1;
  logic       sda_pull_n, scl_pull_n, irq;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  tw_start_hold u_tw_start_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_in     (sda_m & sda_pull_n),
    .scl_in     (scl_m & scl_pull_n),
    .sda_pull_n (sda_pull_n),
    .scl_pull_n (scl_pull_n),
    .irq        (irq),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
  );

  function automatic logic [7:0] exp_status(input logic flag, input logic ovf, input logic [3:0] cnt);
    return {flag, ovf, 2'b00, cnt};
  endfunction

  function automatic logic exp_sda_pull_n(input logic oe, input logic [7:0] d);
    return !(oe && !d[7]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic xfer(input logic [7:0] b, input logic ie);
    logic [7:0] v;
    wr(2'd2, {7'd0, ie});
    sda_m = 1'b0; waitn(6);
    rd(2'd1, v);
    chk("R2 start flag", v[7], 1);
    chk("R3 irq with flag", irq, ie);
    scl_m = 1'b0; waitn(6);
    chk("R4 hold on first fall", scl_pull_n, 0);
    waitn(10);
    chk("R4 hold persists", scl_pull_n, 0);
    rd(2'd1, v);
    chk("R10 fall not counted", v[3:0], 0);
    wr(2'd1, 8'h80); waitn(4);
    chk("R5 release", scl_pull_n, 1);
    chk("R3 irq after clear", irq, 0);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitn(4);
      scl_m = 1'b1; waitn(4);
      scl_m = 1'b0; waitn(4);
    end
    rd(2'd0, v);
    chk("R7 byte MSB first", v, b);
    rd(2'd1, v);
    chk("R8 wrap and overflow", v, exp_status(1'b0, 1'b1, 4'd0));
    sda_m = 1'b0; waitn(4);
    scl_m = 1'b1; waitn(4);
    sda_m = 1'b1; waitn(4);
    wr(2'd1, 8'h40);
    rd(2'd1, v);
    chk("R8 overflow cleared", v, exp_status(1'b0, 1'b0, 4'd0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    waitn(3);
    rst_n = 1'b1;
    waitn(2);
    // R1 reset state
    rd(2'd1, v); chk("R1 status", v, 0);
    rd(2'd0, v); chk("R1 data", v, 8'hFF);
    rd(2'd2, v); chk("R1 ctrl", v, 0);
    chk("R1 scl released", scl_pull_n, 1);
    chk("R1 sda released", sda_pull_n, 1);
    chk("R1 irq", irq, 0);

    // R2 negative: SDA fall with SCL low
    scl_m = 1'b0; waitn(4);
    sda_m = 1'b0; waitn(6);
    rd(2'd1, v); chk("R2 no start when SCL low", v[7], 0);
    sda_m = 1'b1; waitn(4);
    scl_m = 1'b1; waitn(4);
    wr(2'd1, 8'h40);

    // R9 collision of detect and clear
    @(negedge clk); sda_m = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h80;
    @(negedge clk); reg_wr = 1'b0;
    rd(2'd1, v); chk("R9 set wins over clear", v[7], 1);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk("R2 clear by write one", v[7], 0);
    sda_m = 1'b1; waitn(4);

    // R5 clear flag with counter non-zero keeps hold
    sda_m = 1'b0; waitn(6);
    scl_m = 1'b0; waitn(6);
    chk("R4 hold", scl_pull_n, 0);
    wr(2'd1, 8'h83); waitn(6);
    chk("R5 hold kept while counter non-zero", scl_pull_n, 0);
    wr(2'd1, 8'h00); waitn(4);
    chk("R5 release after counter zero", scl_pull_n, 1);
    scl_m = 1'b1; waitn(4);
    sda_m = 1'b1; waitn(4);
    wr(2'd1, 8'h40);

    // R7 direct load
    wr(2'd0, 8'h3C);
    rd(2'd0, v); chk("R7 data load", v, 8'h3C);

    // R6 random SDA drive with SCL low so no start forms
    scl_m = 1'b0; waitn(4);
    for (int k = 0; k < 12; k++) begin
      logic [7:0] d;
      logic       oe;
      d  = 8'($urandom);
      oe = 1'($urandom % 2);
      wr(2'd0, d);
      wr(2'd2, {6'd0, oe, 1'b0});
      #1 chk("R6 sda pull", sda_pull_n, exp_sda_pull_n(oe, d));
    end
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    scl_m = 1'b1; waitn(4);
    wr(2'd1, 8'h40);

    // random transfers plus directed corner bytes
    xfer(8'h00, 1'b1);
    xfer(8'hFF, 1'b0);
    for (int k = 0; k < 10; k++) xfer(8'($urandom), 1'($urandom % 2));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule